// File: doc/BRIEF.md
# Dual Store Queue with Burst Flush

The block holds two write-combining queues of eight 32-bit words each, sixteen entries in all. Software fills the entries with longword writes and can read any entry back. A prefetch command then drains one whole queue to external memory as a single 32-byte burst of eight beats.

The burst target address is formed in one of two ways. In untranslated mode, the low address bits come from the prefetch address and the upper bits come from a programmable high-address register. There is one such register for each queue. In translated mode, the prefetch address is already the external address, and it is used after masking. Only one burst runs at a time. While it runs, the queue being drained is locked against writes, and the other queue stays writable.

Top module: `sq_burst_unit`

## Requirements
- R1: After reset, bus_valid is 0, pf_ready and acc_ready are 1, and all sixteen entries read as zero.
- R2: An accepted access with acc_we=1 stores acc_wdata into entry acc_addr[5:2]. Bit 5 picks the queue and bits 4:2 pick the word. An accepted access with acc_we=0 returns that entry on rd_data, with rd_valid high, one cycle later.
- R3: A flush is accepted when pf_valid and pf_ready are both high. The queue is chosen by pf_addr[5]. From the next cycle, the queue's words 0 to 7 are presented in order on bus_data, one beat per cycle with bus_ready high, and bus_last is high on word 7 only.
- R4: With pf_xlat=0, bus_addr is (pf_addr & 0x03FFFFE0) OR'd with the selected queue's high register shifted to bit 24.
- R5: With pf_xlat=1, bus_addr is pf_addr & 0x1FFFFFE0.
- R6: Two 3-bit high registers are written by hi_we, with the register chosen by hi_sel. A flush uses the value held at its accept edge.
- R7: Draining a queue leaves its contents unchanged.
- R8: pf_ready is low while a burst is active. A held request is accepted in the cycle after the last beat.
- R9: During a burst, a write to the queue being drained sees acc_ready low and is not stored. Writes to the other queue, and all reads, are accepted.
- R10: While bus_valid is high and bus_ready is low, bus_addr, bus_data and bus_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Entry access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address; bits 5:2 select the entry |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| hi_we | input | 1 | High register write strobe |
| hi_sel | input | 1 | High register select |
| hi_wdata | input | 3 | High register value |
| pf_valid | input | 1 | Flush request |
| pf_xlat | input | 1 | 1 = pf_addr already translated |
| pf_addr | input | 32 | Prefetch address |
| pf_ready | output | 1 | Flush request accepted |
| bus_valid | output | 1 | Burst beat valid |
| bus_ready | input | 1 | Burst beat taken |
| bus_addr | output | 32 | Burst start address, 32-byte aligned |
| bus_data | output | 32 | Beat data |
| bus_last | output | 1 | Final beat of the burst |

## Verification
The bench goes after four corner cases.

- A flush request held through an active burst. A design without the stall would restart the burst mid-stream, or drop the request.
- A write to the locked queue during its burst. A design that stored it would send mixed old and new words, and would break the rule that contents survive a flush.
- Back-pressure on the bus. A design that advanced the beat without a handshake would skip words.
- A high-register write in the same cycle as a flush accept, and the two address modes back to back. A design that picked the wrong register, mask or mode would send the burst to a wrong address.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_AW     = 32;
  localparam int SQ_DW     = 32;
  localparam int SQ_NQ     = 2;
  localparam int SQ_WORDS  = 8;
  localparam int SQ_WSEL_W = $clog2(SQ_WORDS);
  localparam int SQ_WSEL_LSB = 2;
  localparam int SQ_QSEL_BIT = SQ_WSEL_LSB + SQ_WSEL_W;

  typedef struct packed {
    logic             q;
    logic [SQ_AW-1:0] tgt;
  } sq_flush_t;
endpackage

// File: rtl/sq_storage.sv
module sq_storage
  import sq_pkg::*;
#(
  parameter int DATA_W = SQ_DW,
  parameter int NQ     = SQ_NQ,
  parameter int WORDS  = SQ_WORDS,
  localparam int WW    = $clog2(WORDS),
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [QW-1:0]     wr_q,
  input  logic [WW-1:0]     wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [QW-1:0]     rd_q,
  input  logic [WW-1:0]     rd_word,
  output logic [DATA_W-1:0] rd_out,
  input  logic              lock_on,
  input  logic [QW-1:0]     lock_q,
  input  logic [WW-1:0]     b_word,
  output logic [DATA_W-1:0] b_out
);
  logic [DATA_W-1:0] mem_q [NQ][WORDS];

  for (genvar gq = 0; gq < NQ; gq++) begin : g_queue
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
      logic              en;
      logic [DATA_W-1:0] nxt;
      always_comb begin
        en  = wr_en && (wr_q == QW'(gq)) && (wr_word == WW'(gw));
        nxt = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mem_q[gq][gw] <= '0;
        else if (en) mem_q[gq][gw] <= nxt;
      end
    end
  end

  always_comb begin
    rd_out = mem_q[rd_q][rd_word];
    b_out  = mem_q[lock_q][b_word];
  end

  // R9: the queue under drain never takes a write
  assert_locked_queue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_on) |-> (wr_q != lock_q));
endmodule

// File: rtl/sq_target.sv
module sq_target
  import sq_pkg::*;
#(
  parameter int ADDR_W  = SQ_AW,
  parameter int HI_W    = 3,
  parameter int HI_LSB  = 24,
  parameter int RAW_MSB = 25,
  parameter int XL_MSB  = 28,
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(31),
  localparam logic [ADDR_W-1:0] RAW_M = ((ADDR_W'(1) << (RAW_MSB+1)) - ADDR_W'(1)) & ALIGN,
  localparam logic [ADDR_W-1:0] XL_M  = ((ADDR_W'(1) << (XL_MSB+1))  - ADDR_W'(1)) & ALIGN
) (
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_xlat,
  input  logic [HI_W-1:0]   hi0,
  input  logic [HI_W-1:0]   hi1,
  output sq_flush_t         req
);
  logic [HI_W-1:0] hi_sel;
  always_comb begin
    req.q   = pf_addr[SQ_QSEL_BIT];
    hi_sel  = req.q ? hi1 : hi0;
    if (pf_xlat) req.tgt = pf_addr & XL_M;
    else         req.tgt = (pf_addr & RAW_M) | (ADDR_W'(hi_sel) << HI_LSB);
  end
endmodule

// File: rtl/sq_burst.sv
module sq_burst
  import sq_pkg::*;
#(
  parameter int ADDR_W = SQ_AW,
  parameter int WORDS  = SQ_WORDS,
  localparam int WW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  sq_flush_t         start_req,
  input  logic              bus_ready,
  output logic              busy,
  output logic              cur_q,
  output logic [WW-1:0]     beat,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  logic              busy_d, q_d;
  logic [WW-1:0]     beat_d;
  logic [ADDR_W-1:0] addr_d;
  logic              adv, load_en;

  always_comb begin
    last    = busy && (beat == WW'(WORDS-1));
    adv     = busy && bus_ready;
    load_en = start && !busy;
    busy_d  = busy;
    beat_d  = beat;
    q_d     = cur_q;
    addr_d  = cur_addr;
    if (load_en) begin
      busy_d = 1'b1;
      beat_d = '0;
      q_d    = start_req.q;
      addr_d = start_req.tgt;
    end else if (adv) begin
      beat_d = beat + WW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else begin
      busy <= busy_d;
      beat <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= 1'b0;
      cur_addr <= '0;
    end else if (load_en) begin
      cur_q    <= q_d;
      cur_addr <= addr_d;
    end
  end

  // R10: a stalled beat holds its address and position
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ready) |=> (busy && $stable(beat) && $stable(cur_addr)));
  // R3: taking the last beat ends the burst
  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && bus_ready) |=> !busy);
  // R3: a burst begins at word 0
  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (beat == '0));
  // R8: no new accept while a burst runs
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/sq_burst_unit.sv
module sq_burst_unit
  import sq_pkg::*;
#(
  parameter int ADDR_W = SQ_AW,
  parameter int DATA_W = SQ_DW,
  parameter int HI_W   = 3,
  parameter int HI_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hi_we,
  input  logic              hi_sel,
  input  logic [HI_W-1:0]   hi_wdata,
  input  logic              pf_valid,
  input  logic              pf_xlat,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_ready,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_last
);
  localparam int WW = SQ_WSEL_W;

  logic [HI_W-1:0]   hi_r [SQ_NQ];
  logic              busy, cur_q, acc_q, wr_en, rd_en, start;
  logic [WW-1:0]     beat, acc_w;
  logic [DATA_W-1:0] rd_word;
  sq_flush_t         req;

  always_comb begin
    acc_q     = acc_addr[SQ_QSEL_BIT];
    acc_w     = acc_addr[SQ_QSEL_BIT-1:SQ_WSEL_LSB];
    acc_ready = !(acc_we && busy && (acc_q == cur_q));
    wr_en     = acc_valid && acc_we && acc_ready;
    rd_en     = acc_valid && !acc_we;
    pf_ready  = !busy;
    start     = pf_valid && pf_ready;
    bus_valid = busy;
  end

  for (genvar gh = 0; gh < SQ_NQ; gh++) begin : g_hi
    logic en;
    always_comb en = hi_we && (hi_sel == 1'(gh));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hi_r[gh] <= '0;
      else if (en) hi_r[gh] <= hi_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  sq_storage #(.DATA_W(DATA_W), .NQ(SQ_NQ), .WORDS(SQ_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_q(acc_q), .wr_word(acc_w), .wr_data(acc_wdata),
    .rd_q(acc_q), .rd_word(acc_w), .rd_out(rd_word),
    .lock_on(busy), .lock_q(cur_q), .b_word(beat), .b_out(bus_data)
  );

  sq_target #(.ADDR_W(ADDR_W), .HI_W(HI_W), .HI_LSB(HI_LSB)) u_tgt (
    .pf_addr(pf_addr), .pf_xlat(pf_xlat), .hi0(hi_r[0]), .hi1(hi_r[1]), .req(req)
  );

  sq_burst #(.ADDR_W(ADDR_W), .WORDS(SQ_WORDS)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_req(req), .bus_ready(bus_ready),
    .busy(busy), .cur_q(cur_q), .beat(beat), .cur_addr(bus_addr), .last(bus_last)
  );

  // R2: a read is answered exactly one cycle later
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R4: every burst address is 32-byte aligned
  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[4:0] == 5'd0));
  // R10: beat data holds while the bus stalls
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> $stable(bus_data));
endmodule

// File: tb/tb_sq_burst_unit.sv
`timescale 1ns/1ps
module tb_sq_burst_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, acc_valid, acc_we, acc_ready, rd_valid;
  logic [31:0] acc_addr, acc_wdata, rd_data, pf_addr, bus_addr, bus_data;
  logic        hi_we, hi_sel, pf_valid, pf_xlat, pf_ready, bus_valid, bus_ready, bus_last;
  logic [2:0]  hi_wdata;

  sq_burst_unit dut (.*);

  int checks = 0, fails = 0;
  logic [31:0] m_sq [16];
  logic [2:0]  m_hi [2];
  bit          m_busy, m_q, m_xlat, m_rdv, m_stalled;
  int          m_beat;
  logic [31:0] m_tgt, m_rd;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_we = 0; acc_addr = 0; acc_wdata = 0;
    hi_we = 0; hi_sel = 0; hi_wdata = 0;
    pf_valid = 0; pf_xlat = 0; pf_addr = 0; bus_ready = 1;
  endtask

  // Compare against the model, advance the model, move to the next negedge.
  task automatic step();
    bit a_rdy;
    #1;
    a_rdy = !(acc_we && m_busy && (acc_addr[5] == m_q));
    chk("R8 pf_ready", pf_ready, !m_busy);
    chk("R9 acc_ready", acc_ready, a_rdy);
    chk("R3 bus_valid", bus_valid, m_busy);
    if (m_busy) begin
      chk(m_xlat ? "R5 bus_addr" : "R4 bus_addr", bus_addr, m_tgt);
      chk(m_stalled ? "R10 bus_data" : "R7 bus_data", bus_data, m_sq[m_q*8 + m_beat]);
      chk("R3 bus_last", bus_last, m_beat == 7);
    end
    chk("R2 rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk("R2 rd_data", rd_data, m_rd);
    m_rdv = acc_valid && !acc_we;
    if (m_rdv) m_rd = m_sq[acc_addr[5:2]];
    if (m_busy) begin
      m_stalled = !bus_ready;
      if (bus_ready) begin
        if (m_beat == 7) m_busy = 0; else m_beat++;
      end
    end else if (pf_valid) begin
      m_busy = 1; m_beat = 0; m_q = pf_addr[5]; m_xlat = pf_xlat; m_stalled = 0;
      m_tgt = pf_xlat ? (pf_addr & 32'h1FFF_FFE0)
                      : ((pf_addr & 32'h03FF_FFE0) | (32'(m_hi[pf_addr[5]]) << 24));
    end
    if (acc_valid && acc_we && a_rdy) m_sq[acc_addr[5:2]] = acc_wdata;
    if (hi_we) m_hi[hi_sel] = hi_wdata;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flush(input logic [31:0] a, input bit x);
    bit took;
    pf_valid = 1; pf_addr = a; pf_xlat = x;
    do begin took = !m_busy; step(); end while (!took);
    pf_valid = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    for (int i = 0; i < 16; i++) m_sq[i] = 0;
    m_hi[0] = 0; m_hi[1] = 0; m_busy = 0; m_rdv = 0; m_beat = 0; m_q = 0;
    m_xlat = 0; m_stalled = 0; m_tgt = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 pf_ready", pf_ready, 1);
    chk("R1 acc_ready", acc_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R1: entries read zero
    acc_valid = 1; acc_we = 0; acc_addr = 32'h0000_0014; step();
    acc_addr = 32'h0000_003C; step();
    // R2: fill all entries, upper address bits are don't-care
    for (int i = 0; i < 16; i++) begin
      acc_we = 1; acc_addr = 32'hE000_0000 | (i << 2); acc_wdata = 32'hA500_0000 + i * 32'h0101_0101;
      step();
    end
    acc_we = 0;
    for (int i = 15; i >= 0; i--) begin acc_addr = i << 2; step(); end
    idle();
    // R6: program both high registers
    hi_we = 1; hi_sel = 0; hi_wdata = 3'b101; step();
    hi_sel = 1; hi_wdata = 3'b010; step();
    idle();
    // R4: untranslated drain of queue 0
    flush(32'hE3AB_CDC0, 0);
    // R9: other queue writable, drained queue locked
    acc_valid = 1; acc_we = 1; acc_addr = 32'h24; acc_wdata = 32'h1111_2222; step();
    acc_addr = 32'h08; acc_wdata = 32'hDEAD_BEEF; step();
    // R8: a held request for queue 1 waits, R5 translated
    acc_valid = 0;
    flush(32'hFFFF_FFE4, 1);
    // R10: back-pressure during the queue 1 burst
    for (int i = 0; i < 20; i++) begin bus_ready = (i % 3) != 0; step(); end
    idle();
    // R6: high register written in the accept cycle, old value is used
    hi_we = 1; hi_sel = 1; hi_wdata = 3'b111;
    flush(32'h0000_1020, 0);
    idle();
    repeat (10) step();
    // R7: contents unchanged after drain
    acc_valid = 1;
    for (int i = 0; i < 16; i++) begin acc_addr = i << 2; step(); end
    idle();
    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      acc_valid = lfsr[0]; acc_we = lfsr[1]; acc_addr = {lfsr[31:6], lfsr[5:2], 2'b00};
      acc_wdata = lfsr ^ 32'h5A5A_0F0F;
      hi_we = (lfsr[9:7] == 3'd0); hi_sel = lfsr[10]; hi_wdata = lfsr[13:11];
      pf_valid = (lfsr[16:14] == 3'd0); pf_xlat = lfsr[17]; pf_addr = {lfsr[7:0], lfsr[31:8]};
      bus_ready = lfsr[20] | lfsr[21];
      step();
    end
    idle();
    repeat (12) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule